// File: doc/BRIEF.md
# DMA Request Pin Generator for a Serial Port

This block produces the two active-low request pins that a serial port presents to a DMA controller. One pin says the transmit side can accept data, the other says the receive side has data waiting. It also produces two transmitter status bits that software can poll: one for an empty transmit holding buffer, and one for a completely idle transmitter. The block only watches occupancy counts and control bits. The FIFOs, the shift registers and the register interface sit in neighbouring blocks.

A single mode bit selects how the pins behave. In single-transfer mode each pin follows the empty/non-empty state of its buffer, so a DMA controller moves one character per request. Block mode needs the FIFOs to be enabled. In block mode each pin follows the programmed trigger levels, with hysteresis, so that one request can cover a burst:

- Transmit: the request rises when the level falls below the trigger and is withdrawn only when the FIFO is full.
- Receive: the request rises once the level reaches the trigger. It is withdrawn only when the FIFO has drained to empty, even though characters keep arriving past the trigger until the FIFO is full.

All outputs are registered. Each reflects the inputs sampled at the previous rising clock edge.

Top module: `uart_dma_ready`

## Requirements
- R1: While reset is held, and on the first clock after it, tx_rdy_n = 0, rx_rdy_n = 1, thr_empty = 1 and tx_idle = 1.
- R2: Every output is registered: a change of input has no effect on any output until the next rising clock edge.
- R3: In single-transfer mode the next tx_rdy_n is 0 when tx_level is 0, and 1 otherwise. Single-transfer mode is blk_mode = 0, or fifo_en = 0.
- R4: In single-transfer mode the next rx_rdy_n is 0 when rx_level is non-zero, and 1 when it is 0.
- R5: In block mode (blk_mode = 1 and fifo_en = 1) with tx_level not equal to DEPTH, tx_rdy_n goes to 0 when tx_level < tx_trig.
- R6: In block mode tx_rdy_n goes to 1 when tx_level equals DEPTH. This holds even when tx_level < tx_trig.
- R7: In block mode with tx_trig <= tx_level < DEPTH, tx_rdy_n keeps its previous value.
- R8: In block mode with rx_level non-zero and rx_level >= rx_trig, rx_rdy_n goes to 0.
- R9: In block mode with rx_level = 0, rx_rdy_n goes to 1.
- R10: In block mode with 0 < rx_level < rx_trig, rx_rdy_n keeps its previous value. A request raised at the trigger therefore stays asserted while the FIFO fills on to DEPTH and while it drains back down below the trigger.
- R11: thr_empty is 1 exactly when tx_level was 0 at the previous edge.
- R12: tx_idle is 1 exactly when tx_level was 0 and tsr_busy was 0 at the previous edge.
- R13: With fifo_en = 0, blk_mode has no effect: both pins follow R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | 1 = FIFOs enabled; 0 = single holding register |
| blk_mode | input | 1 | 0 = single-transfer mode, 1 = block mode |
| tx_level | input | CW | Characters held in the transmit FIFO, 0..DEPTH |
| rx_level | input | CW | Characters held in the receive FIFO, 0..DEPTH |
| tx_trig | input | CW | Transmit trigger level |
| rx_trig | input | CW | Receive trigger level |
| tsr_busy | input | 1 | Transmit shift register still shifting a character |
| tx_rdy_n | output | 1 | Active-low transmit DMA request |
| rx_rdy_n | output | 1 | Active-low receive DMA request |
| thr_empty | output | 1 | Transmit holding buffer empty |
| tx_idle | output | 1 | Holding buffer and shift register both empty |

CW = $clog2(DEPTH+1); the default DEPTH is 32.

## Verification
Two transmit-side conditions can hold in the same cycle: the FIFO is full, and the level is below the trigger. The bench provokes this by programming trigger values above DEPTH, which the CW-wide trigger field allows, while the level sits at DEPTH. The withdrawn request (R6) must win. The other collision is a switch between modes while a level sits inside a hysteresis band. Random walks of the levels, combined with random mode flips, hit both cases often. Each result is judged against a bench model that carries its own copy of the previous pin state.

// File: rtl/dma_rdy_pkg.sv
// Package: shared types for the DMA request pin generator.
// Assumes: nothing beyond standard SystemVerilog.
package dma_rdy_pkg;

    // Transfer signalling style that applies to both pins.
    typedef enum logic {
        XFER_SINGLE = 1'b0,
        XFER_BLOCK  = 1'b1
    } xfer_mode_e;

    // Block signalling only makes sense with FIFOs; otherwise fall back.
    function automatic xfer_mode_e pick_mode(input logic fifo_on, input logic blk);
        return (fifo_on && blk) ? XFER_BLOCK : XFER_SINGLE;
    endfunction

endpackage

// File: rtl/dma_tx_ready.sv
// Module: dma_tx_ready
// Drives the active-low transmit DMA request. In single mode the request
// is asserted while the transmit buffer is empty. In block mode it is
// asserted once the level drops below the trigger, withdrawn at full,
// and held in between.
// Assumes: level never exceeds DEPTH; the trigger may be any CW-bit value.
module dma_tx_ready
    import dma_rdy_pkg::*;
#(
    parameter  int DEPTH = 32,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  xfer_mode_e    mode,
    input  logic [CW-1:0] level,
    input  logic [CW-1:0] trig,
    output logic          rdy_n
);

    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    logic rdy_n_nxt;

    // Next request state: level rule in single mode, hysteresis in block mode.
    always_comb begin
        rdy_n_nxt = rdy_n;
        if (mode == XFER_SINGLE) begin
            rdy_n_nxt = (level != '0);
        end else if (level == FULL_LVL) begin
            rdy_n_nxt = 1'b1;
        end else if (level < trig) begin
            rdy_n_nxt = 1'b0;
        end
    end

    // Request register; asserted out of reset because the buffer starts empty.
    always_ff @(posedge clk) begin
        if (!rst_n) rdy_n <= 1'b0;
        else        rdy_n <= rdy_n_nxt;
    end

    AST_TX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == XFER_SINGLE) |-> (rdy_n == ($past(level) != '0))); // R3
    AST_TX_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == XFER_BLOCK && $past(level) == FULL_LVL) |-> rdy_n); // R6
    AST_TX_BELOW_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == XFER_BLOCK && $past(level) != FULL_LVL
         && $past(level) < $past(trig)) |-> !rdy_n); // R5
    AST_TX_HOLD_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == XFER_BLOCK && $past(level) != FULL_LVL
         && $past(level) >= $past(trig)) |-> $stable(rdy_n)); // R7

endmodule

// File: rtl/dma_rx_ready.sv
// Module: dma_rx_ready
// Drives the active-low receive DMA request. In single mode the request
// is asserted whenever a character is waiting. In block mode it is
// asserted once the level reaches the trigger, held while the FIFO keeps
// filling or partly drains, and withdrawn only at empty.
// Assumes: level never exceeds DEPTH.
module dma_rx_ready
    import dma_rdy_pkg::*;
#(
    parameter  int DEPTH = 32,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  xfer_mode_e    mode,
    input  logic [CW-1:0] level,
    input  logic [CW-1:0] trig,
    output logic          rdy_n
);

    logic rdy_n_nxt;

    // Next request state: data-present rule in single mode, hysteresis in block mode.
    always_comb begin
        rdy_n_nxt = rdy_n;
        if (mode == XFER_SINGLE) begin
            rdy_n_nxt = (level == '0);
        end else if (level == '0) begin
            rdy_n_nxt = 1'b1;
        end else if (level >= trig) begin
            rdy_n_nxt = 1'b0;
        end
    end

    // Request register; idle (high) out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) rdy_n <= 1'b1;
        else        rdy_n <= rdy_n_nxt;
    end

    AST_RX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == XFER_SINGLE) |-> (rdy_n == ($past(level) == '0))); // R4
    AST_RX_EMPTY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == XFER_BLOCK && $past(level) == '0) |-> rdy_n); // R9
    AST_RX_AT_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == XFER_BLOCK && $past(level) != '0
         && $past(level) >= $past(trig)) |-> !rdy_n); // R8
    AST_RX_HOLD_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == XFER_BLOCK && $past(level) != '0
         && $past(level) < $past(trig)) |-> $stable(rdy_n)); // R10

endmodule

// File: rtl/tx_line_status.sv
// Module: tx_line_status
// Registers the two transmitter status bits: holding buffer empty, and
// whole transmitter idle (buffer empty and shift register not busy).
// Assumes: tsr_busy is high for the full time a character is shifting.
module tx_line_status #(
    parameter  int DEPTH = 32,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] level,
    input  logic          tsr_busy,
    output logic          thr_empty,
    output logic          tx_idle
);

    logic buf_empty;

    // Decode an empty transmit buffer.
    always_comb buf_empty = (level == '0);

    // Status registers; both report empty out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_empty <= 1'b1;
            tx_idle   <= 1'b1;
        end else begin
            thr_empty <= buf_empty;
            tx_idle   <= buf_empty && !tsr_busy;
        end
    end

    AST_IDLE_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> thr_empty); // R12
    AST_EMPTY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (thr_empty == ($past(level) == '0))); // R11
    AST_BUSY_BLOCKS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tsr_busy)) |-> !tx_idle); // R12

endmodule

// File: rtl/uart_dma_ready.sv
// Module: uart_dma_ready (top)
// Generates the transmit/receive DMA request pins and the transmitter
// status bits from the FIFO occupancy counts and trigger levels.
// Assumes: FIFO levels come from neighbouring FIFO blocks and stay in
// 0..DEPTH; with FIFOs disabled the level is 0 or 1 (single holding register).
module uart_dma_ready
    import dma_rdy_pkg::*;
#(
    parameter  int DEPTH = 32,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          blk_mode,
    input  logic [CW-1:0] tx_level,
    input  logic [CW-1:0] rx_level,
    input  logic [CW-1:0] tx_trig,
    input  logic [CW-1:0] rx_trig,
    input  logic          tsr_busy,
    output logic          tx_rdy_n,
    output logic          rx_rdy_n,
    output logic          thr_empty,
    output logic          tx_idle
);

    xfer_mode_e mode;

    // Effective signalling mode; block mode requires the FIFOs (R13).
    always_comb mode = pick_mode(fifo_en, blk_mode);

    dma_tx_ready #(.DEPTH(DEPTH)) u_tx_ready (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .level (tx_level),
        .trig  (tx_trig),
        .rdy_n (tx_rdy_n)
    );

    dma_rx_ready #(.DEPTH(DEPTH)) u_rx_ready (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .level (rx_level),
        .trig  (rx_trig),
        .rdy_n (rx_rdy_n)
    );

    tx_line_status #(.DEPTH(DEPTH)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (tx_level),
        .tsr_busy  (tsr_busy),
        .thr_empty (thr_empty),
        .tx_idle   (tx_idle)
    );

    AST_RESET_VALUES: assert property (@(posedge clk)
        $past(!rst_n) |-> (!tx_rdy_n && rx_rdy_n && thr_empty && tx_idle)); // R1
    AST_NOFIFO_TX: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(fifo_en)) |-> (tx_rdy_n == !thr_empty)); // R13
    AST_REGISTERED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(rx_rdy_n) && $past(mode) == XFER_SINGLE)
        |-> (rx_rdy_n == ($past(rx_level) == '0))); // R2

endmodule

// File: tb/sim_uart_dma_ready.sv
`timescale 1ns/1ps
module sim_uart_dma_ready;

    localparam int DEPTH = 32;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fifo_en = 1'b0, blk_mode = 1'b0, tsr_busy = 1'b0;
    logic [CW-1:0] tx_level = '0, rx_level = '0, tx_trig = '0, rx_trig = '0;
    logic          tx_rdy_n, rx_rdy_n, thr_empty, tx_idle;

    int checks = 0;
    int errors = 0;

    // expected registered outputs
    logic e_tx = 1'b0, e_rx = 1'b1, e_thr = 1'b1, e_idle = 1'b1;

    always #5 clk = ~clk;

    uart_dma_ready #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .blk_mode(blk_mode),
        .tx_level(tx_level), .rx_level(rx_level), .tx_trig(tx_trig), .rx_trig(rx_trig),
        .tsr_busy(tsr_busy), .tx_rdy_n(tx_rdy_n), .rx_rdy_n(rx_rdy_n),
        .thr_empty(thr_empty), .tx_idle(tx_idle)
    );

    function automatic logic model_tx(logic fe, logic bm, int lvl, int trg, logic prev);
        if (!(fe && bm)) return (lvl != 0);
        if (lvl == DEPTH) return 1'b1;
        if (lvl < trg)    return 1'b0;
        return prev;
    endfunction

    function automatic logic model_rx(logic fe, logic bm, int lvl, int trg, logic prev);
        if (!(fe && bm)) return (lvl == 0);
        if (lvl == 0)    return 1'b1;
        if (lvl >= trg)  return 1'b0;
        return prev;
    endfunction

    function automatic string tx_tag(logic fe, logic bm, int lvl, int trg);
        if (!fe && bm)   return "R13";
        if (!(fe && bm)) return "R3";
        if (lvl == DEPTH) return "R6";
        if (lvl < trg)   return "R5";
        return "R7";
    endfunction

    function automatic string rx_tag(logic fe, logic bm, int lvl, int trg);
        if (!fe && bm)   return "R13";
        if (!(fe && bm)) return "R4";
        if (lvl == 0)    return "R9";
        if (lvl >= trg)  return "R8";
        return "R10";
    endfunction

    task automatic chk(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // Drive one input set just after a falling edge, confirm no early change,
    // then compare registered outputs at the following falling edge.
    task automatic step(logic fe, logic bm, int txl, int rxl, int txt, int rxt, logic busy);
        fifo_en  = fe;  blk_mode = bm;  tsr_busy = busy;
        tx_level = CW'(txl); rx_level = CW'(rxl);
        tx_trig  = CW'(txt); rx_trig  = CW'(rxt);
        #1;
        chk("R2", "tx_rdy_n before edge", tx_rdy_n, e_tx);
        chk("R2", "rx_rdy_n before edge", rx_rdy_n, e_rx);
        @(posedge clk);
        e_tx   = model_tx(fe, bm, txl, txt, e_tx);
        e_rx   = model_rx(fe, bm, rxl, rxt, e_rx);
        e_thr  = (txl == 0);
        e_idle = (txl == 0) && !busy;
        @(negedge clk);
        chk(tx_tag(fe, bm, txl, txt), "tx_rdy_n", tx_rdy_n, e_tx);
        chk(rx_tag(fe, bm, rxl, rxt), "rx_rdy_n", rx_rdy_n, e_rx);
        chk("R11", "thr_empty", thr_empty, e_thr);
        chk("R12", "tx_idle", tx_idle, e_idle);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int tl, rl, tt, rt;
        logic fe, bm;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: values during reset
        chk("R1", "tx_rdy_n reset", tx_rdy_n, 1'b0);
        chk("R1", "rx_rdy_n reset", rx_rdy_n, 1'b1);
        chk("R1", "thr_empty reset", thr_empty, 1'b1);
        chk("R1", "tx_idle reset", tx_idle, 1'b1);
        rst_n = 1'b1;

        // R10/R8/R9: receive block, fill past trigger to full, drain
        step(1, 1, 0, 0, 8, 8, 0);
        step(1, 1, 0, 4, 8, 8, 0);   // below trigger, stays high
        step(1, 1, 0, 8, 8, 8, 0);   // reach trigger
        step(1, 1, 0, 20, 8, 8, 0);
        step(1, 1, 0, 32, 8, 8, 0);  // full, still requesting
        step(1, 1, 0, 5, 8, 8, 0);   // drained under trigger, held low
        step(1, 1, 0, 0, 8, 8, 0);   // empty, withdrawn
        // R6/R7/R5: transmit block
        step(1, 1, 32, 0, 8, 8, 1);
        step(1, 1, 20, 0, 8, 8, 1);  // held high
        step(1, 1, 7, 0, 8, 8, 1);   // below trigger
        step(1, 1, 20, 0, 8, 8, 0);  // held low
        step(1, 1, 32, 0, 40, 8, 0); // full while below trigger: full wins
        // R13: FIFOs off, block bit ignored
        step(0, 1, 1, 1, 8, 8, 0);
        step(0, 1, 0, 0, 8, 8, 0);
        step(0, 1, 0, 1, 8, 8, 1);
        // zero trigger corner
        step(1, 1, 3, 5, 0, 0, 0);
        // R3/R4 single mode
        step(1, 0, 0, 3, 8, 8, 1);
        step(1, 0, 5, 0, 8, 8, 0);

        // random walks mixed with jumps
        tl = 0; rl = 0; tt = 8; rt = 8; fe = 1; bm = 1;
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 15) == 0) begin
                tl = $urandom_range(0, DEPTH);
                rl = $urandom_range(0, DEPTH);
            end else begin
                tl = tl + int'($urandom_range(0, 2)) - 1;
                rl = rl + int'($urandom_range(0, 2)) - 1;
                if (tl < 0) tl = 0;
                if (tl > DEPTH) tl = DEPTH;
                if (rl < 0) rl = 0;
                if (rl > DEPTH) rl = DEPTH;
            end
            if ($urandom_range(0, 63) == 0) tt = $urandom_range(0, (1 << CW) - 1);
            if ($urandom_range(0, 63) == 0) rt = $urandom_range(0, (1 << CW) - 1);
            if ($urandom_range(0, 31) == 0) bm = ~bm;
            if ($urandom_range(0, 63) == 0) fe = ~fe;
            step(fe, bm, tl, rl, tt, rt, logic'($urandom_range(0, 1)));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule